// File: doc/BRIEF.md
# Clock Output Stop and Gating

This block takes two free-running source clocks, a PCI-rate clock and a CPU-rate clock, and drives a bank of gated copies of them. The gated outputs are a set of single-ended PCI clocks, one dedicated PCI clock that the stop input never affects, and a differential CPU pair made of a true and a complement output. A small configuration store, written from a control clock, holds one enable bit per output and one free-running override bit per gated PCI output. An active-low stop input, which may change at any time, halts every gated PCI output whose override bit is clear.

The stop request and the configuration bits pass through a two-flop synchroniser in each source-clock domain. A gate register per output then updates on the falling edge of its source clock, so a gate only opens or closes while that clock is low. An output therefore starts or stops with whole high pulses and never produces a shortened one. A stopped or disabled single-ended output rests low. A disabled CPU pair rests with the true output low and the complement output high.

Top module: `clkgate_top`

## Requirements
- R1: While `pciStopN` is 0, every gated PCI output (`pciClkOut[i]`) whose free-running bit `cfgPciFree[i]` is 0 stops.
- R2: An output that is stopped or disabled (enable bit 0) is held at 0 and does not toggle. This applies to `pciClkOut`, `pciFreeClkOut` and `cpuOutT`.
- R3: After reset all enable bits are 1: `cfgPciEn` bits [PCI_GATED-1:0] select the gated outputs, bit PCI_GATED selects `pciFreeClkOut`, plus the CPU pair enable. With the stop input high, every output runs once reset is released.
- R4: A gated PCI output whose free-running bit is 1 keeps running while `pciStopN` is 0. All free-running bits are 0 after reset.
- R5: `pciFreeClkOut` is never affected by `pciStopN`. It behaves as if its free-running bit were permanently 1.
- R6: When the CPU pair enable is 0, `cpuOutT` is held at 0 and `cpuOutC` at 1. At all times after reset `cpuOutC` is the inverse of `cpuOutT`.
- R7: An enable bit of 0 stops its output even when its free-running bit is 1.
- R8: No output produces a high pulse shorter than the high phase of its source clock. The gate of each output changes only while its source clock is low.
- R9: While `rstN` is 0, all PCI outputs are 0, `cpuOutT` is 0 and `cpuOutC` is 1.
- R10: A configuration write (`cfgWrite` high at a `ctlClk` rising edge loads all three fields) reaches the affected outputs within four periods of their source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctlClk | input | 1 | Clock for the configuration store |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Loads all configuration fields on a `ctlClk` rising edge |
| cfgPciEn | input | PCI_GATED+1 | PCI enables; bit i for gated output i, top bit for the dedicated clock |
| cfgPciFree | input | PCI_GATED | Free-running override, one bit per gated PCI output |
| cfgCpuEn | input | 1 | CPU pair enable |
| pciClkIn | input | 1 | Free-running PCI source clock |
| cpuClkIn | input | 1 | Free-running CPU source clock |
| pciStopN | input | 1 | Asynchronous active-low stop request for gated PCI outputs |
| pciClkOut | output | PCI_GATED | Gated PCI clocks |
| pciFreeClkOut | output | 1 | Dedicated PCI clock, immune to the stop input |
| cpuOutT | output | 1 | CPU pair true output |
| cpuOutC | output | 1 | CPU pair complement output |

## Verification
A wrong synchroniser or gate state appears at the ports as an output that keeps toggling when it should rest, or that rests when it should run. It can also appear as a pair resting with the wrong polarity. Any of these is visible within a few source-clock periods of the stimulus. A gate that changes during the high phase shows up at once as a high pulse narrower than half the source period. Measuring every pulse width therefore exposes a misplaced gate edge on the first affected cycle.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  parameter int PCI_GATED = 6;
  localparam int PCI_W = PCI_GATED + 1;

  typedef struct packed {
    logic [PCI_W-1:0] pciOpen;
    logic             cpuOpen;
  } gateCtl_t;
endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
(
  input  logic                 ctlClk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [PCI_W-1:0]     cfgPciEn,
  input  logic [PCI_GATED-1:0] cfgPciFree,
  input  logic                 cfgCpuEn,
  input  logic                 pciClkIn,
  input  logic                 cpuClkIn,
  input  logic                 pciStopN,
  output gateCtl_t             gateCtl,
  output logic [PCI_W-1:0]     pciEnSync,
  output logic [PCI_GATED-1:0] pciFreeSync,
  output logic                 stopSyncN
);
  localparam int SYNC_W = PCI_W + PCI_GATED + 1;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

  logic [PCI_W-1:0]     enReg;
  logic [PCI_GATED-1:0] freeReg;
  logic                 cpuEnReg;
  logic [SYNC_W-1:0]    pciSyncQ;
  logic                 cpuEnSync;

  // configuration store in the control domain
  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '1;
      freeReg  <= '0;
      cpuEnReg <= 1'b1;
    end else if (cfgWrite) begin
      enReg    <= cfgPciEn;
      freeReg  <= cfgPciFree;
      cpuEnReg <= cfgCpuEn;
    end
  end

  clkgate_sync #(.W(SYNC_W), .RST(SYNC_RST)) pciSync (
    .clk (pciClkIn),
    .rstN(rstN),
    .d   ({pciStopN, freeReg, enReg}),
    .q   (pciSyncQ)
  );

  clkgate_sync #(.W(1), .RST(1'b0)) cpuSync (
    .clk (cpuClkIn),
    .rstN(rstN),
    .d   (cpuEnReg),
    .q   (cpuEnSync)
  );

  assign pciEnSync   = pciSyncQ[PCI_W-1:0];
  assign pciFreeSync = pciSyncQ[PCI_W +: PCI_GATED];
  assign stopSyncN   = pciSyncQ[SYNC_W-1];

  // enable has priority; override exempts an output from the stop request
  for (genvar i = 0; i < PCI_GATED; i++) begin : gOpen
    assign gateCtl.pciOpen[i] = pciEnSync[i] & (stopSyncN | pciFreeSync[i]);
  end
  assign gateCtl.pciOpen[PCI_GATED] = pciEnSync[PCI_GATED];
  assign gateCtl.cpuOpen            = cpuEnSync;
endmodule

// File: rtl/clkgate_path.sv
module clkgate_path
  import clkgate_pkg::*;
(
  input  logic                 pciClkIn,
  input  logic                 cpuClkIn,
  input  logic                 rstN,
  input  gateCtl_t             gateCtl,
  output logic [PCI_W-1:0]     pciGate,
  output logic                 cpuGate,
  output logic [PCI_GATED-1:0] pciClkOut,
  output logic                 pciFreeClkOut,
  output logic                 cpuOutT,
  output logic                 cpuOutC
);
  // gate registers move only on the falling edge, i.e. into the low phase
  always_ff @(negedge pciClkIn or negedge rstN) begin
    if (!rstN) pciGate <= '0;
    else       pciGate <= gateCtl.pciOpen;
  end

  always_ff @(negedge cpuClkIn or negedge rstN) begin
    if (!rstN) cpuGate <= 1'b0;
    else       cpuGate <= gateCtl.cpuOpen;
  end

  for (genvar i = 0; i < PCI_GATED; i++) begin : gPciOut
    assign pciClkOut[i] = pciClkIn & pciGate[i];
  end
  assign pciFreeClkOut = pciClkIn & pciGate[PCI_GATED];

  // parked pair: true low, complement high
  assign cpuOutT = cpuClkIn & cpuGate;
  assign cpuOutC = ~(cpuClkIn & cpuGate);
endmodule

// File: rtl/clkgate_top.sv
module clkgate_top
  import clkgate_pkg::*;
(
  input  logic                 ctlClk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [PCI_W-1:0]     cfgPciEn,
  input  logic [PCI_GATED-1:0] cfgPciFree,
  input  logic                 cfgCpuEn,
  input  logic                 pciClkIn,
  input  logic                 cpuClkIn,
  input  logic                 pciStopN,
  output logic [PCI_GATED-1:0] pciClkOut,
  output logic                 pciFreeClkOut,
  output logic                 cpuOutT,
  output logic                 cpuOutC
);
  gateCtl_t             gateCtl;
  logic [PCI_W-1:0]     pciEnSync;
  logic [PCI_GATED-1:0] pciFreeSync;
  logic                 stopSyncN;
  logic [PCI_W-1:0]     pciGate;
  logic                 cpuGate;

  clkgate_ctrl ctrl (
    .ctlClk     (ctlClk),
    .rstN       (rstN),
    .cfgWrite   (cfgWrite),
    .cfgPciEn   (cfgPciEn),
    .cfgPciFree (cfgPciFree),
    .cfgCpuEn   (cfgCpuEn),
    .pciClkIn   (pciClkIn),
    .cpuClkIn   (cpuClkIn),
    .pciStopN   (pciStopN),
    .gateCtl    (gateCtl),
    .pciEnSync  (pciEnSync),
    .pciFreeSync(pciFreeSync),
    .stopSyncN  (stopSyncN)
  );

  clkgate_path path (
    .pciClkIn     (pciClkIn),
    .cpuClkIn     (cpuClkIn),
    .rstN         (rstN),
    .gateCtl      (gateCtl),
    .pciGate      (pciGate),
    .cpuGate      (cpuGate),
    .pciClkOut    (pciClkOut),
    .pciFreeClkOut(pciFreeClkOut),
    .cpuOutT      (cpuOutT),
    .cpuOutC      (cpuOutC)
  );
endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk
  import clkgate_pkg::*;
(
  input logic                 ctlClk,
  input logic                 rstN,
  input logic                 pciClkIn,
  input logic                 cpuClkIn,
  input logic [PCI_W-1:0]     pciEnSync,
  input logic [PCI_GATED-1:0] pciFreeSync,
  input logic                 stopSyncN,
  input logic [PCI_W-1:0]     pciGate,
  input logic                 cpuGate,
  input logic [PCI_GATED-1:0] pciClkOut,
  input logic                 pciFreeClkOut,
  input logic                 cpuOutT,
  input logic                 cpuOutC
);
  AST_STOP_CLOSES_GATE: assert property (@(negedge pciClkIn) disable iff (!rstN)
    ((pciGate[PCI_GATED-1:0] & $past(~pciFreeSync & {PCI_GATED{~stopSyncN}})) == '0)); // R1

  AST_OVERRIDE_KEEPS_OPEN: assert property (@(negedge pciClkIn) disable iff (!rstN)
    ((pciGate[PCI_GATED-1:0] | ~$past(pciEnSync[PCI_GATED-1:0] & pciFreeSync)) == '1)); // R4

  AST_DEDICATED_IMMUNE: assert property (@(negedge pciClkIn) disable iff (!rstN)
    $past(pciEnSync[PCI_GATED]) |-> pciGate[PCI_GATED]); // R5

  AST_CLOSED_OUTPUT_LOW: assert property (@(negedge pciClkIn) disable iff (!rstN)
    (({pciFreeClkOut, pciClkOut} & ~pciGate) == '0)); // R2

  AST_CPU_PARK_LEVEL: assert property (@(negedge cpuClkIn) disable iff (!rstN)
    !cpuGate |-> (!cpuOutT && cpuOutC)); // R6

  AST_CPU_PAIR_OPPOSED: assert property (@(posedge ctlClk) disable iff (!rstN)
    cpuOutT != cpuOutC); // R6
endmodule

bind clkgate_top clkgate_chk chk (
  .ctlClk       (ctlClk),
  .rstN         (rstN),
  .pciClkIn     (pciClkIn),
  .cpuClkIn     (cpuClkIn),
  .pciEnSync    (pciEnSync),
  .pciFreeSync  (pciFreeSync),
  .stopSyncN    (stopSyncN),
  .pciGate      (pciGate),
  .cpuGate      (cpuGate),
  .pciClkOut    (pciClkOut),
  .pciFreeClkOut(pciFreeClkOut),
  .cpuOutT      (cpuOutT),
  .cpuOutC      (cpuOutC)
);

// File: tb/clkgate_top_test.sv
`timescale 1ns/1ps
module clkgate_top_test;
  import clkgate_pkg::*;
  localparam int G = PCI_GATED;
  localparam int W = G + 3;               // [G-1:0] pci, G dedicated, G+1 true, G+2 complement
  localparam logic [W-1:0] PARK = {1'b1, {(W-1){1'b0}}};

  logic ctlClk = 0, pciClkIn = 0, cpuClkIn = 0;
  logic rstN = 0, cfgWrite = 0, pciStopN = 1, cfgCpuEn = 1;
  logic [G:0]   cfgPciEn = '1;
  logic [G-1:0] cfgPciFree = '0;
  logic [G-1:0] pciClkOut;
  logic pciFreeClkOut, cpuOutT, cpuOutC;

  always #2  ctlClk   = ~ctlClk;   // 250 MHz
  always #12 pciClkIn = ~pciClkIn;
  always #5  cpuClkIn = ~cpuClkIn;

  clkgate_top uut (
    .ctlClk(ctlClk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgPciEn(cfgPciEn),
    .cfgPciFree(cfgPciFree), .cfgCpuEn(cfgCpuEn), .pciClkIn(pciClkIn),
    .cpuClkIn(cpuClkIn), .pciStopN(pciStopN), .pciClkOut(pciClkOut),
    .pciFreeClkOut(pciFreeClkOut), .cpuOutT(cpuOutT), .cpuOutC(cpuOutC)
  );

  int checks = 0, fails = 0, pushed = 0, served = 0;
  typedef struct { string req; logic [W-1:0] run; } exp_t;
  exp_t expQ[$];

  wire [W-1:0] obs = {cpuOutC, cpuOutT, pciFreeClkOut, pciClkOut};

  task automatic expectRun(string req, logic [W-1:0] run);
    exp_t item;
    item.req = req; item.run = run;
    expQ.push_back(item);
    pushed++;
    wait (served == pushed);
  endtask

  task automatic writeCfg(logic [G:0] en, logic [G-1:0] fr, logic cpu);
    @(negedge ctlClk);
    cfgPciEn = en; cfgPciFree = fr; cfgCpuEn = cpu; cfgWrite = 1;
    @(negedge ctlClk);
    cfgWrite = 0;
  endtask

  // monitor: watch all outputs for a window and compare with the expected item
  initial begin
    forever begin
      exp_t item;
      logic [W-1:0] prev;
      int tog [W];
      wait (expQ.size() > 0);
      item = expQ[0];
      for (int b = 0; b < W; b++) tog[b] = 0;
      #0.3;
      prev = obs;
      repeat (150) begin
        #1;
        for (int b = 0; b < W; b++) if (obs[b] != prev[b]) tog[b]++;
        prev = obs;
      end
      for (int b = 0; b < W; b++) begin
        checks++;
        if (item.run[b]) begin
          if (tog[b] < 2) begin
            fails++;
            $display("FAIL %s line %0d: toggles=%0d expected running", item.req, b, tog[b]);
          end
        end else if (tog[b] != 0 || obs[b] != PARK[b]) begin
          fails++;
          $display("FAIL %s line %0d: toggles=%0d level=%0b expected parked at %0b",
                   item.req, b, tog[b], obs[b], PARK[b]);
        end
      end
      void'(expQ.pop_front());
      served++;
    end
  end

  // R8: every high pulse must span a full source high phase
  wire [G+1:0] pulseLines = {cpuOutT, pciFreeClkOut, pciClkOut};
  for (genvar i = 0; i <= G + 1; i++) begin : gPulse
    localparam real HALF = (i == G + 1) ? 5.0 : 12.0;
    realtime riseT = 0;
    always @(posedge pulseLines[i]) riseT = $realtime;
    always @(negedge pulseLines[i]) begin
      if (rstN && riseT > 0) begin
        checks++;
        if ($realtime - riseT < HALF - 0.01) begin
          fails++;
          $display("FAIL R8 line %0d: high width %0t expected %0.1f", i, $realtime - riseT, HALF);
        end
      end
    end
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #50;
    expectRun("R9", '0);                                    // held in reset
    @(negedge ctlClk); rstN = 1;
    #200;
    expectRun("R3", '1);                                    // defaults: all running
    #7 pciStopN = 0;
    #200;
    expectRun("R1 R5", {3'b111, {G{1'b0}}});                // gated stopped, dedicated and cpu run
    writeCfg('1, 6'b001001, 1'b1);
    #200;
    expectRun("R4", {3'b111, 6'b001001});
    writeCfg({1'b1, 6'b111110}, 6'b001001, 1'b1);
    #200;
    expectRun("R7", {3'b111, 6'b001000});                   // enable beats override
    #3 pciStopN = 1;
    writeCfg({1'b1, 6'b111011}, 6'b000000, 1'b0);
    #200;
    expectRun("R6 R2", {3'b001, 6'b111011});                // cpu parked T=0 C=1
    writeCfg({1'b0, 6'b111111}, 6'b000000, 1'b1);
    #200;
    expectRun("R2", {3'b110, 6'b111111});                   // dedicated disabled
    writeCfg({1'b0, 6'b111111}, 6'b000000, 1'b0);
    #45;
    expectRun("R10", {3'b000, 6'b111111});                  // cpu parked within four periods
    writeCfg('1, 6'b000000, 1'b1);
    #100;
    expectRun("R10", '1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule